// File: doc/BRIEF.md
# Binary64 to Binary32 Store-Path Narrower

This block converts a 64-bit IEEE 754 binary64 bit pattern into a 32-bit binary32 bit pattern, as a floating-point unit does when it writes a double-precision register value to a single-precision memory word. The conversion is purely a matter of moving bits. It does no rounding, raises no exception flags, and leaves NaN payloads alone. Signalling NaNs are not quieted.

The exponent field of the input decides which of three paths is taken:
- **Direct path:** used when the single-precision exponent range can hold the value, and also for infinities and NaNs. Output bits are selected straight from the input.
- **Denormal path:** used when the value lands in the single-precision denormal range. The significand, with its hidden one restored, goes through a variable right shift.
- **Flush path:** used for anything smaller than that. The result is a zero that keeps the input sign.

A single register stage holds the result, and a valid strobe travels alongside it.

Top module: `f64_store_narrow`

## Requirements
- R1: The input exponent is bits 62:52. When it is greater than 896, out_data[31:30] equals in_data[63:62] and out_data[29:0] equals in_data[58:29].
- R2: An input with exponent 2047 (infinity or NaN) gives out_data[30:23] = 8'hFF. Its out_data[22:0] equals in_data[51:29] unchanged, so a signalling NaN stays signalling.
- R3: When the exponent lies in 874..896, out_data[30:0] is the low 31 bits of {1'b1, in_data[51:0]} shifted right by (926 − exponent). The shift amount is always between 30 and 52.
- R4: When the exponent is below 874, out_data[30:0] is zero. This covers true zeros and also non-zero values out of range.
- R5: Fraction bits that fall off the result are dropped without rounding. Setting them never changes the output.
- R6: out_data[31] equals in_data[63] on every path.
- R7: out_valid is high exactly one cycle after in_valid is high. The matching result appears on out_data in that same cycle.
- R8: While in_valid is low, out_data keeps its previous value.
- R9: A synchronous active-high reset clears out_valid and out_data to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 64 | Binary64 bit pattern to narrow |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 32 | Registered binary32 bit pattern |

## Verification
The direct path is checked with exact normals of both signs, with a large exponent outside the single-precision range, and with the smallest single-precision normal exponent (897). Together these show the bit-select and the lower boundary of the path. Infinity, a quiet NaN and a signalling NaN with only its lowest kept fraction bit set show that specials pass through untouched and that no quieting takes place.

Exponents 896, 880 and 874 check both ends of the shift range and one midpoint, and a negative denormal checks sign handling on that path. Exponent 873 and signed zeros check the flush path. Inputs with all discarded fraction bits set show that no rounding occurs.

Holding in_valid low while in_data changes shows that out_data is held.

// File: rtl/f64n_pkg.sv
package f64n_pkg;
    // Formats
    localparam int DBL_W     = 64;
    localparam int SGL_W     = 32;
    localparam int DEXP_W    = 11;
    localparam int DFRAC_W   = 52;
    localparam int SEXP_W    = 8;
    localparam int SFRAC_W   = 23;
    localparam int MAG_W     = SGL_W - 1;          // output bits below the sign
    localparam int SIG_W     = DFRAC_W + 1;        // significand with hidden one
    localparam int SHAMT_W   = $clog2(SIG_W);

    // Exponent bounds that pick the path
    localparam logic [DEXP_W-1:0] EXP_DIRECT_MIN = DEXP_W'(897);
    localparam logic [DEXP_W-1:0] EXP_DENORM_MIN = DEXP_W'(874);
    localparam logic [DEXP_W-1:0] SHIFT_BASE     = DEXP_W'(926);
    localparam int                SHAMT_LO       = 30;
    localparam int                SHAMT_HI       = 52;

    typedef enum logic [1:0] {
        PATH_DIRECT = 2'd0,
        PATH_DENORM = 2'd1,
        PATH_FLUSH  = 2'd2
    } path_e;

    typedef struct packed {
        logic               sign;
        logic [DEXP_W-1:0]  exp;
        logic [DFRAC_W-1:0] frac;
    } dbl_t;

    typedef struct packed {
        path_e               path;
        logic [SHAMT_W-1:0]  shamt;
    } sel_t;

    function automatic path_e pick_path(input logic [DEXP_W-1:0] e);
        if (e >= EXP_DIRECT_MIN)      return PATH_DIRECT;
        else if (e >= EXP_DENORM_MIN) return PATH_DENORM;
        else                          return PATH_FLUSH;
    endfunction
endpackage

// File: rtl/f64n_classify.sv
module f64n_classify
    import f64n_pkg::*;
(
    input  logic [DEXP_W-1:0] exp_in,
    output sel_t              sel
);
    always_comb begin
        sel.path  = pick_path(exp_in);
        sel.shamt = SHAMT_W'(SHIFT_BASE - exp_in);
    end

    // R3: on the denormal path the shift amount stays inside the shifter span
    always_comb begin
        if (sel.path == PATH_DENORM) begin
            assert_shamt_range_R3: assert (sel.shamt >= SHAMT_W'(SHAMT_LO) &&
                                           sel.shamt <= SHAMT_W'(SHAMT_HI))
                else $error("shift amount out of span");
        end
    end
endmodule

// File: rtl/f64n_rshift.sv
module f64n_rshift #(
    parameter int DATA_W  = 53,
    parameter int SHAMT_W = 6,
    parameter int KEEP_W  = 31
) (
    input  logic [DATA_W-1:0]  din,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [KEEP_W-1:0]  dout
);
    logic [DATA_W-1:0] stage [SHAMT_W+1];

    assign stage[0] = din;

    generate
        for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            if (STEP >= DATA_W) begin : g_full
                assign stage[k+1] = shamt[k] ? '0 : stage[k];
            end else begin : g_part
                assign stage[k+1] = shamt[k] ? (stage[k] >> STEP) : stage[k];
            end
        end
    endgenerate

    assign dout = stage[SHAMT_W][KEEP_W-1:0];
endmodule

// File: rtl/f64n_assemble.sv
module f64n_assemble
    import f64n_pkg::*;
(
    input  dbl_t              src,
    input  path_e             path,
    input  logic [MAG_W-1:0]  denorm_mag,
    output logic [SGL_W-1:0]  result
);
    logic [MAG_W-1:0] mag;

    always_comb begin
        unique case (path)
            PATH_DIRECT: mag = {src.exp[DEXP_W-1],
                                src.exp[SEXP_W-2:0],
                                src.frac[DFRAC_W-1 -: SFRAC_W]};
            PATH_DENORM: mag = denorm_mag;
            default:     mag = '0;
        endcase
        result = {src.sign, mag};
    end
endmodule

// File: rtl/f64_store_narrow.sv
module f64_store_narrow
    import f64n_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [63:0]      in_data,
    output logic             out_valid,
    output logic [31:0]      out_data
);
    dbl_t              src;
    sel_t              sel;
    logic [MAG_W-1:0]  denorm_mag;
    logic [SGL_W-1:0]  result;

    assign src = dbl_t'(in_data);

    f64n_classify u_classify (
        .exp_in (src.exp),
        .sel    (sel)
    );

    f64n_rshift #(
        .DATA_W  (SIG_W),
        .SHAMT_W (SHAMT_W),
        .KEEP_W  (MAG_W)
    ) u_rshift (
        .din   ({1'b1, src.frac}),
        .shamt (sel.shamt),
        .dout  (denorm_mag)
    );

    f64n_assemble u_assemble (
        .src        (src),
        .path       (sel.path),
        .denorm_mag (denorm_mag),
        .result     (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= result;
        end
    end

    assert_valid_rise_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_fall_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    assert_sign_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_data[SGL_W-1] == $past(in_data[DBL_W-1]));
    assert_special_exp_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[62:52] == 11'h7FF) |=> out_data[30:23] == 8'hFF);
    assert_flush_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[62:52] < 11'd874) |=> out_data[30:0] == 31'd0);
endmodule

// File: tb/f64_store_narrow_tb.sv
module f64_store_narrow_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    f64_store_narrow u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive one valid word, sample after the capturing edge
    task automatic push(input string req, input logic [63:0] d, input logic [31:0] exp);
        @(negedge clk);
        in_data  = d;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check(req, out_data, exp);
    endtask

    task automatic test_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 valid", {31'd0, out_valid}, 32'd0);
        check("R9 data", out_data, 32'd0);
        rst = 1'b0;
    endtask

    task automatic test_direct;
        push("R1 one",        64'h3FF0000000000000, 32'h3F800000);
        push("R6 neg normal", 64'hC004000000000000, 32'hC0200000);
        push("R1 min normal", 64'h3810000000000000, 32'h00800000);
        push("R1 big exp",    64'h7E30000000000000, 32'h71800000);
    endtask

    task automatic test_special;
        push("R2 inf",  64'h7FF0000000000000, 32'h7F800000);
        push("R2 qnan", 64'h7FF8000000000000, 32'h7FC00000);
        push("R2 snan", 64'h7FF0000020000000, 32'h7F800001);
    endtask

    task automatic test_denorm;
        push("R3 exp896",     64'h3800000000000000, 32'h00400000);
        push("R3 exp874",     64'h36A0000000000000, 32'h00000001);
        push("R3 exp880",     64'h370FFFFFFFFFFFFF, 32'h0000007F);
        push("R6 neg denorm", 64'hB800000000000000, 32'h80400000);
    endtask

    task automatic test_flush;
        push("R4 exp873",     64'h3690000000000000, 32'h00000000);
        push("R4 neg exp873", 64'hB690000000000000, 32'h80000000);
        push("R4 zero",       64'h0000000000000000, 32'h00000000);
        push("R6 neg zero",   64'h8000000000000000, 32'h80000000);
    endtask

    task automatic test_truncate;
        push("R5 lsb set",   64'h3FF0000000000001, 32'h3F800000);
        push("R5 tail ones", 64'h3FF000001FFFFFFF, 32'h3F800000);
    endtask

    task automatic test_hold;
        push("R8 preload", 64'h4000000000000000, 32'h40000000);
        @(negedge clk);
        in_data = 64'hBFF0000000000000;
        repeat (3) @(negedge clk);
        check("R7 valid low", {31'd0, out_valid}, 32'd0);
        check("R8 held", out_data, 32'h40000000);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        test_direct();
        test_special();
        test_denorm();
        test_flush();
        test_truncate();
        test_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule